// File: doc/BRIEF.md
# Serial ADC Reader

This block is the host-side controller for a 16-clock serial analog-to-digital converter link. It drives the active-low chip select and derives the serial clock from the system clock by a fixed divider. It shifts in the converter's reply on the serial clock's falling edges, keeps only the data field for the configured resolution, and hands the value to the user with a one-cycle strobe. The result field starts after four leading zeros, most significant bit first.

The user side is small. A start pulse requests one conversion. A shutdown request sends the converter into low power. A busy flag shows when requests are ignored. After reset, and after any shutdown, the converter's first reply is unusable. The controller therefore runs a discarded warm-up frame on its own, waits the quiet time, and then runs the real frame. The user still sees one strobe per start. Shutdown is made by raising chip select part-way through a frame, after a chosen falling edge, which aborts the conversion.

Top module: `serial_adc_reader`

## Requirements
- R1: Out of reset, chip select is high, the serial clock is low, busy is low and the data-valid strobe is low.
- R2: A conversion frame holds chip select low for exactly 33*DIV_HALF system cycles. The serial clock period is 2*DIV_HALF cycles. The clock is low when chip select falls, so its first edge is rising. The frame holds exactly 16 falling edges, and the clock is low whenever chip select is high.
- R3: The result is the RES_BITS bits sampled at falling edges 5 through 4+RES_BITS. The line is sampled just before each edge, and the first bit taken is the most significant. The four bits before the field and any bits after it have no effect on the result.
- R4: The data-valid strobe is one system cycle wide. It rises in the same cycle as the chip select rise that ends a valid frame, and the result holds its value until the next strobe.
- R5: Between any chip select rise and the next fall, chip select stays high for at least QUIET_CYC cycles. Busy stays high during that quiet time.
- R6: The first start after reset runs a warm-up frame with no strobe. Exactly QUIET_CYC cycles after that frame ends, the real frame begins. Only the real frame's data is delivered, with a single strobe. Later starts run one frame each.
- R7: A shutdown request while idle and awake runs a frame whose chip select rises DIV_HALF cycles after falling edge SHDN_FALLS (2..10). That frame gives no strobe.
- R8: The first start after a shutdown again runs a warm-up frame followed by a real frame, as in R6.
- R9: A start or shutdown request that arrives while busy is ignored. A shutdown request while already shut down is ignored.
- R10: When start and shutdown requests arrive in the same idle cycle while awake, the shutdown is carried out and the start is dropped.
- R11: Busy rises on the edge that accepts a request and falls only when the controller is idle again. Chip select is high whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion (pulse) |
| shdn_req_i | input | 1 | Request converter shutdown (pulse) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| dv_o | output | 1 | One-cycle strobe marking a fresh result |
| result_o | output | RES_BITS | Most recent conversion result |
| busy_o | output | 1 | High while a frame or quiet time is running |

## Verification
The hardest situation to reach is the automatic warm-up chain. It happens only after reset, after a shutdown frame, or after a shutdown that wins a tie with a start. The stimulus reaches it by issuing shutdowns in each of these ways and then a start. The bench's converter model stays asleep until a full frame wakes it, and it sends a distinct garbage word during the warm-up frame, so a delivered warm-up result or a missing warm-up frame shows up in the result and in the frame count.

// File: rtl/serial_adc_reader_pkg.sv
// Shared constants and types for the serial ADC reader.
// Assumes a 16-clock frame whose data field follows four leading zeros.
package serial_adc_reader_pkg;

    localparam int FRAME_FALLS = 16;
    localparam int LEAD_ZEROS  = 4;
    localparam int HALF_W      = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_QUIET
    } seq_st_t;

    typedef enum logic [1:0] {
        FK_REAL,
        FK_DUMMY,
        FK_SHDN
    } frame_kind_t;

endpackage

// File: rtl/adc_clk_div.sv
// Half-period timer: while enabled, pulses tick_o once every DIV_HALF cycles.
// Assumes DIV_HALF >= 1. The count restarts from zero whenever enable drops.
module adc_clk_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    localparam int CW = $clog2(DIV_HALF) + 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    // Tick on the last count of each half period.
    always_comb tick_o = en_i && (cnt == LAST);

    // Count system cycles within a half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || tick_o) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/adc_frame_shift.sv
// Shift register for the data field, with a result register loaded at frame end.
// Assumes the sequencer asserts shift_i only on the data-field falling edges.
module adc_frame_shift #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                bit_i,
    input  logic                load_i,
    output logic [RES_BITS-1:0] result_o
);

    logic [RES_BITS-1:0] sr;

    // Shift the sampled bit in MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (shift_i) sr <= {sr[RES_BITS-2:0], bit_i};
    end

    // Hold the result until the next valid frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      result_o <= '0;
        else if (load_i) result_o <= sr;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Frame sequencer: drives chip select and the serial clock, and picks warm-up,
// real or shutdown frames. Enforces the quiet time and raises the strobe.
// Assumes QUIET_CYC >= 1, 2 <= SHDN_FALLS <= 10, and 2 <= RES_BITS <= 12.
module adc_seq_fsm
    import serial_adc_reader_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int SHDN_FALLS = 4,
    parameter int QUIET_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic shdn_i,
    input  logic tick_i,
    output logic div_en_o,
    output logic shift_en_o,
    output logic load_o,
    output logic cs_n_o,
    output logic sclk_o,
    output logic dv_o,
    output logic busy_o
);

    localparam int QW = $clog2(QUIET_CYC) + 1;
    localparam logic [QW-1:0]     Q_LAST     = QW'(QUIET_CYC - 1);
    localparam logic [HALF_W-1:0] FULL_END   = HALF_W'(2 * FRAME_FALLS + 1);
    localparam logic [HALF_W-1:0] SHDN_END   = HALF_W'(2 * SHDN_FALLS + 1);
    localparam logic [HALF_W-2:0] FIRST_DATA = (HALF_W-1)'(LEAD_ZEROS + 1);
    localparam logic [HALF_W-2:0] LAST_DATA  = (HALF_W-1)'(LEAD_ZEROS + RES_BITS);

    seq_st_t           state;
    frame_kind_t       kind;
    logic [HALF_W-1:0] half_cnt;
    logic [HALF_W-1:0] half_next;
    logic [HALF_W-1:0] end_half;
    logic [HALF_W-2:0] fall_no;
    logic [QW-1:0]     q_cnt;
    logic              asleep;
    logic              fresh;
    logic              chain;
    logic              run;
    logic              fin;

    // Decode the next half period, the frame end and the sample strobes.
    always_comb begin
        run        = (state == ST_RUN);
        half_next  = half_cnt + 1'b1;
        fall_no    = half_next[HALF_W-1:1];
        end_half   = (kind == FK_SHDN) ? SHDN_END : FULL_END;
        fin        = run && tick_i && (half_next == end_half);
        shift_en_o = run && tick_i && !half_next[0]
                     && (fall_no >= FIRST_DATA) && (fall_no <= LAST_DATA);
        load_o     = fin && (kind == FK_REAL);
        div_en_o   = run;
        busy_o     = (state != ST_IDLE);
    end

    // Main sequencer: accept requests, run frames, time the quiet gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= FK_REAL;
            half_cnt <= '0;
            q_cnt    <= '0;
            asleep   <= 1'b0;
            fresh    <= 1'b1;
            chain    <= 1'b0;
            cs_n_o   <= 1'b1;
            sclk_o   <= 1'b0;
            dv_o     <= 1'b0;
        end else begin
            dv_o <= load_o;
            unique case (state)
                ST_IDLE: begin
                    half_cnt <= '0;
                    if (shdn_i && !asleep) begin
                        kind   <= FK_SHDN;
                        state  <= ST_RUN;
                        cs_n_o <= 1'b0;
                    end else if (start_i) begin
                        kind   <= (asleep || fresh) ? FK_DUMMY : FK_REAL;
                        chain  <= asleep || fresh;
                        state  <= ST_RUN;
                        cs_n_o <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (tick_i) begin
                        half_cnt <= half_next;
                        sclk_o   <= half_next[0] && !fin;
                    end
                    if (fin) begin
                        cs_n_o <= 1'b1;
                        q_cnt  <= '0;
                        state  <= ST_QUIET;
                        if (kind == FK_DUMMY) begin
                            fresh  <= 1'b0;
                            asleep <= 1'b0;
                        end else if (kind == FK_SHDN) begin
                            fresh  <= 1'b1;
                            asleep <= 1'b1;
                        end
                    end
                end
                ST_QUIET: begin
                    q_cnt <= q_cnt + 1'b1;
                    if (q_cnt == Q_LAST) begin
                        if (chain) begin
                            chain    <= 1'b0;
                            kind     <= FK_REAL;
                            half_cnt <= '0;
                            cs_n_o   <= 1'b0;
                            state    <= ST_RUN;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serial_adc_reader.sv
// Top level: ties the half-period timer, the frame sequencer and the data
// shift register together. Assumes sdata_i is stable around serial clock edges.
module serial_adc_reader #(
    parameter int RES_BITS   = 12,
    parameter int DIV_HALF   = 4,
    parameter int QUIET_CYC  = 16,
    parameter int SHDN_FALLS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                shdn_req_i,
    input  logic                sdata_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                dv_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                busy_o
);

    logic div_en;
    logic tick;
    logic shift_en;
    logic load;

    adc_clk_div #(.DIV_HALF(DIV_HALF)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (div_en),
        .tick_o (tick)
    );

    adc_seq_fsm #(
        .RES_BITS   (RES_BITS),
        .SHDN_FALLS (SHDN_FALLS),
        .QUIET_CYC  (QUIET_CYC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .shdn_i     (shdn_req_i),
        .tick_i     (tick),
        .div_en_o   (div_en),
        .shift_en_o (shift_en),
        .load_o     (load),
        .cs_n_o     (cs_n_o),
        .sclk_o     (sclk_o),
        .dv_o       (dv_o),
        .busy_o     (busy_o)
    );

    adc_frame_shift #(.RES_BITS(RES_BITS)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (shift_en),
        .bit_i    (sdata_i),
        .load_i   (load),
        .result_o (result_o)
    );

endmodule

// File: rtl/serial_adc_reader_chk.sv
// Property checker for the serial ADC reader, bound to every instance.
// Counts the chip select high gap and the falling edges per frame.
module serial_adc_reader_chk #(
    parameter int QUIET_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic dv_o,
    input logic busy_o
);

    logic [31:0] hi_cnt;
    logic [4:0]  fall_cnt;

    // Count cycles with chip select high. Reset counts as a satisfied gap.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_cnt <= 32'(QUIET_CYC);
        else if (!cs_n_o)           hi_cnt <= '0;
        else if (hi_cnt != '1)      hi_cnt <= hi_cnt + 1'b1;
    end

    // Count serial clock falls inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_o)                      fall_cnt <= '0;
        else if (!sclk_o && $past(sclk_o) && fall_cnt != 5'h1f) fall_cnt <= fall_cnt + 1'b1;
    end

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) cs_n_o |-> !sclk_o); // R2
    AST_FALLS_MAX: assert property (@(posedge clk) disable iff (!rst_n) fall_cnt <= 5'd16); // R2
    AST_DV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dv_o |=> !dv_o); // R4
    AST_DV_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) dv_o |-> $rose(cs_n_o)); // R4
    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n_o) |-> hi_cnt >= 32'(QUIET_CYC)); // R5
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> cs_n_o); // R11
    AST_DV_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) dv_o |-> busy_o); // R11

endmodule

bind serial_adc_reader serial_adc_reader_chk #(.QUIET_CYC(QUIET_CYC)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_o (cs_n_o),
    .sclk_o (sclk_o),
    .dv_o   (dv_o),
    .busy_o (busy_o)
);

// File: tb/serial_adc_reader_tb_top.sv
`timescale 1ns/100ps
// Directed bench with a behavioural converter model on the serial link.
module serial_adc_reader_tb_top;

    localparam int RES  = 10;
    localparam int DIVH = 2;
    localparam int QC   = 7;
    localparam int SHF  = 4;
    localparam logic [15:0] GARBAGE = 16'hC3A5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           shdn = 1'b0;
    logic           sdata = 1'b0;
    logic           cs_n;
    logic           sclk;
    logic           dv;
    logic [RES-1:0] result;
    logic           busy;

    int checks = 0;
    int bad = 0;

    // Converter model state
    logic [RES-1:0] m_val = '0;
    logic           m_asleep = 1'b1;
    logic           m_dummy = 1'b0;
    logic [15:0]    m_word = '0;
    int             m_idx = 0;
    int             m_falls = 0;
    int             frames = 0;
    int             last_falls = 0;
    int             last_len = 0;
    int             last_gap = 0;
    int             low_cnt = 0;
    int             high_cnt = 0;
    logic           sclk_at_fall = 1'b1;
    int             dv_cnt = 0;
    int             dv_run = 0;
    int             dv_max = 0;

    always #2.5 clk = ~clk;

    serial_adc_reader #(
        .RES_BITS(RES), .DIV_HALF(DIVH), .QUIET_CYC(QC), .SHDN_FALLS(SHF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shdn_req_i(shdn),
        .sdata_i(sdata), .cs_n_o(cs_n), .sclk_o(sclk), .dv_o(dv),
        .result_o(result), .busy_o(busy)
    );

    // Model: frame start presents the first bit; a sleeping part replies garbage.
    always @(negedge cs_n) begin
        m_dummy      = m_asleep;
        m_word       = m_asleep ? GARBAGE : {4'b0000, m_val, 2'b11};
        m_idx        = 0;
        m_falls      = 0;
        sclk_at_fall = sclk;
        sdata        = m_word[15];
        last_gap     = high_cnt;
    end

    // Model: next bit after each falling edge.
    always @(negedge sclk) begin
        if (!cs_n) begin
            m_falls = m_falls + 1;
            m_idx   = m_idx + 1;
            sdata   = (m_idx <= 15) ? m_word[15 - m_idx] : 1'b0;
        end
    end

    // Model: mode follows how far the frame got.
    always @(posedge cs_n) begin
        if (rst_n) begin
            if (m_falls >= 10)     m_asleep = 1'b0;
            else if (m_falls >= 2) m_asleep = 1'b1;
            frames     = frames + 1;
            last_falls = m_falls;
            last_len   = low_cnt;
        end
    end

    // Observe levels between clock edges.
    always @(negedge clk) begin
        if (!cs_n) begin low_cnt = low_cnt + 1; high_cnt = 0; end
        else       begin high_cnt = high_cnt + 1; low_cnt = 0; end
        if (dv) begin
            dv_cnt = dv_cnt + 1;
            dv_run = dv_run + 1;
            if (dv_run > dv_max) dv_max = dv_run;
        end else dv_run = 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit s, input bit d);
        @(negedge clk);
        start = s;
        shdn  = d;
        @(negedge clk);
        start = 1'b0;
        shdn  = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(dv == 1'b0, "R1 dv", int'(dv), 0);
    endtask

    // R6: first read after reset, with full frame timing checks
    task automatic t_first_read(input logic [RES-1:0] v);
        int f0, d0;
        f0 = frames; d0 = dv_cnt; m_val = v;
        pulse(1'b1, 1'b0);
        check(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
        while (!dv) @(negedge clk);
        check(busy == 1'b1, "R5 busy in quiet", int'(busy), 1);
        wait_idle();
        check(frames - f0 == 2, "R6 warm-up plus real", frames - f0, 2);
        check(dv_cnt - d0 == 1, "R6 one strobe", dv_cnt - d0, 1);
        check(result == v, "R3 result", int'(result), int'(v));
        check(last_gap == QC, "R6 gap before real frame", last_gap, QC);
        check(last_len == 33 * DIVH, "R2 frame length", last_len, 33 * DIVH);
        check(last_falls == 16, "R2 falling edges", last_falls, 16);
        check(sclk_at_fall == 1'b0, "R2 clock low at select", int'(sclk_at_fall), 0);
        check(dv_max == 1, "R4 strobe width", dv_max, 1);
    endtask

    // R3: plain reads with distinct data patterns
    task automatic t_patterns();
        logic [RES-1:0] pats [4] = '{10'h000, 10'h3FF, 10'h155, 10'h001};
        foreach (pats[i]) begin
            int f0;
            f0 = frames; m_val = pats[i];
            pulse(1'b1, 1'b0);
            wait_idle();
            check(frames - f0 == 1, "R6 single frame when awake", frames - f0, 1);
            check(result == pats[i], "R3 pattern", int'(result), int'(pats[i]));
            check(last_gap >= QC, "R5 quiet gap", last_gap, QC);
        end
        repeat (5) @(negedge clk);
        check(result == pats[3], "R4 result held", int'(result), int'(pats[3]));
    endtask

    // R9: requests during a frame are dropped
    task automatic t_busy_ignore();
        int f0, d0;
        f0 = frames; d0 = dv_cnt; m_val = 10'h2C3;
        pulse(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        pulse(1'b1, 1'b1);
        wait_idle();
        check(frames - f0 == 1, "R9 busy requests dropped", frames - f0, 1);
        check(dv_cnt - d0 == 1, "R9 one strobe", dv_cnt - d0, 1);
        check(m_asleep == 1'b0, "R9 still awake", int'(m_asleep), 0);
    endtask

    // R7: shutdown frame
    task automatic t_shutdown(input bit with_start, input string req);
        int f0, d0;
        f0 = frames; d0 = dv_cnt;
        pulse(with_start, 1'b1);
        wait_idle();
        check(frames - f0 == 1, req, frames - f0, 1);
        check(last_falls == SHF, req, last_falls, SHF);
        check(last_len == (2 * SHF + 1) * DIVH, req, last_len, (2 * SHF + 1) * DIVH);
        check(dv_cnt == d0, req, dv_cnt - d0, 0);
        check(m_asleep == 1'b1, req, int'(m_asleep), 1);
    endtask

    // R9: shutdown while asleep does nothing
    task automatic t_shdn_asleep();
        int f0;
        f0 = frames;
        pulse(1'b0, 1'b1);
        check(busy == 1'b0, "R9 asleep shutdown busy", int'(busy), 0);
        repeat (20) @(negedge clk);
        check(frames == f0, "R9 asleep shutdown frames", frames - f0, 0);
    endtask

    // R8: wake from shutdown
    task automatic t_wake(input logic [RES-1:0] v);
        int f0, d0;
        f0 = frames; d0 = dv_cnt; m_val = v;
        pulse(1'b1, 1'b0);
        wait_idle();
        check(frames - f0 == 2, "R8 warm-up after shutdown", frames - f0, 2);
        check(dv_cnt - d0 == 1, "R8 one strobe", dv_cnt - d0, 1);
        check(result == v, "R8 result", int'(result), int'(v));
        check(m_asleep == 1'b0, "R8 awake", int'(m_asleep), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_first_read(10'h2A5);
        t_patterns();
        t_busy_ignore();
        t_shutdown(1'b0, "R7 shutdown frame");
        t_shdn_asleep();
        t_wake(10'h19E);
        t_shutdown(1'b1, "R10 shutdown beats start");
        t_wake(10'h0F1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule